// File: doc/BRIEF.md
# Composite-Field 4-Bit Substitution Box

A nonlinear 4-bit substitution unit for lightweight block ciphers. Its output is computed with field arithmetic, not read from a stored table. The input nibble is an element of GF(2^4) built on x^4 + x + 1. It is carried into a tower representation GF((2^2)^2) by a linear isomorphism. There it is inverted with small subfield squarers, multipliers and a multiply-by-constant. The result is carried back to GF(2^4) and passed through a 4x4 binary affine map.

A parameter chooses the timing. The unit is either purely combinational, or it has one register that splits the datapath between the tower inversion and the back-mapping. In the registered variant a valid strobe travels alongside the data. In the combinational variant the strobe passes straight through.

Top module: `sbox_tower`

## Requirements
- R1: Inputs 0x0 through 0xF produce, in that order, 0x7, 0xE, 0xF, 0x0, 0xD, 0xB, 0x8, 0x1, 0x9, 0x3, 0x4, 0xC, 0x2, 0x5, 0xA, 0x6.
- R2: The zero input has no inverse. It is treated as inverting to zero, so it yields the affine constant 0x7.
- R3: The mapping is bijective: the 16 inputs give 16 distinct outputs.
- R4: The mapping has no fixed point: no input equals its own output.
- R5: The difference distribution table has a maximum of 4 over all nonzero input differences.
- R6: The linearity is 4. Over all nonzero input masks a and output masks b, the largest value of |#{x : parity(a&x) = parity(b&S(x))} - 8| is 4.
- R7: With PIPE=1, data_o and valid_o reflect the data_i and valid_i sampled at the previous rising clock edge, exactly one cycle later.
- R8: With PIPE=1, while rst_ni is low the register is cleared. valid_o is 0 and data_o shows the result for a zero input (0x7).
- R9: With PIPE=0, data_o depends on data_i alone in the same cycle, and valid_o equals valid_i.
- R10: The output is y = A·inv(x) ^ 0x7, where inv is the inverse modulo x^4 + x + 1. With i = inv(x), A sets y3 = i0, y2 = i1, y1 = i2 and y0 = i3 ^ i0 (bit 3 is the MSB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used when PIPE=1 |
| rst_ni | input | 1 | Asynchronous active-low reset, used when PIPE=1 |
| valid_i | input | 1 | Input nibble qualifier |
| data_i | input | 4 | Input nibble |
| valid_o | output | 1 | Output nibble qualifier |
| data_o | output | 4 | Substituted nibble |

## Verification
The latency and injectivity properties compare the output with data_i and valid_i as sampled one edge earlier. They therefore take for granted that valid_i is held low while rst_ni is low and that data_i is never unknown at a clock edge. The bench keeps both inputs at defined values from time zero and holds valid_i low across every reset. It changes inputs only on falling edges, so each rising edge sees settled values.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;
  localparam int NIB_W = 4;
  localparam int SUB_W = NIB_W / 2;

  typedef logic [SUB_W-1:0] gf4_t;
  typedef logic [NIB_W-1:0] nib_t;
  typedef struct packed {
    gf4_t hi;
    gf4_t lo;
  } tower_t;

  localparam nib_t AFF_C = 4'b0111;

  // GF(2^2), basis {1,g}, g^2 = g + 1
  function automatic gf4_t gf4_mul(gf4_t a, gf4_t b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  // squaring equals inversion in GF(2^2)
  function automatic gf4_t gf4_sq(gf4_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // multiply by lambda = g (binary 10)
  function automatic gf4_t gf4_mul_lam(gf4_t a);
    return {a[1] ^ a[0], a[1]};
  endfunction
endpackage

// File: rtl/sbox_field_map.sv
module sbox_field_map
  import sbox_tower_pkg::*;
#(
  parameter bit TO_TOWER = 1'b1
) (
  input  nib_t a_i,
  output nib_t a_o
);
  generate
    if (TO_TOWER) begin : g_fwd
      // binary -> tower: {a11,a10,a01,a00}
      logic a01;
      assign a01 = a_i[2] ^ a_i[3];
      assign a_o = {a_i[3], a_i[1] ^ a01, a01, a_i[0]};
    end else begin : g_bwd
      // tower -> binary
      assign a_o = {a_i[3], a_i[1] ^ a_i[3], a_i[1] ^ a_i[2], a_i[0]};
    end
  endgenerate
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
  import sbox_tower_pkg::*;
(
  input  tower_t a_i,
  output tower_t inv_o
);
  gf4_t delta, delta_inv;

  // (h*b + l)^-1 with b^2 = b + lambda
  assign delta     = gf4_mul_lam(gf4_sq(a_i.hi)) ^ gf4_mul(a_i.hi, a_i.lo) ^ gf4_sq(a_i.lo);
  assign delta_inv = gf4_sq(delta);
  assign inv_o.hi  = gf4_mul(a_i.hi, delta_inv);
  assign inv_o.lo  = gf4_mul(a_i.hi ^ a_i.lo, delta_inv);
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import sbox_tower_pkg::*;
(
  input  nib_t a_i,
  output nib_t y_o
);
  assign y_o = {a_i[0], a_i[1], a_i[2], a_i[3] ^ a_i[0]} ^ AFF_C;
endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbox_tower_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [NIB_W-1:0] data_i,
  output logic            valid_o,
  output logic [NIB_W-1:0] data_o
);
  nib_t   tw_in, bin_inv;
  tower_t tw_inv, tw_stage;

  sbox_field_map #(.TO_TOWER(1'b1)) u_fwd (.a_i(data_i), .a_o(tw_in));
  sbox_tower_inv u_inv (.a_i(tower_t'(tw_in)), .inv_o(tw_inv));

  generate
    if (PIPE) begin : g_pipe
      tower_t stage_q;
      logic   valid_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q <= '0;
          valid_q <= 1'b0;
        end else begin
          stage_q <= tw_inv;
          valid_q <= valid_i;
        end
      end
      assign tw_stage = stage_q;
      assign valid_o  = valid_q;
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign tw_stage = tw_inv;
      assign valid_o  = valid_i;
    end
  endgenerate

  sbox_field_map #(.TO_TOWER(1'b0)) u_bwd (.a_i(nib_t'(tw_stage)), .a_o(bin_inv));
  sbox_affine u_aff (.a_i(bin_inv), .y_o(data_o));
endmodule

// File: rtl/sbox_tower_chk.sv
module sbox_tower_chk #(
  parameter bit PIPE = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] data_i,
  input logic       valid_o,
  input logic [3:0] data_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (PIPE) begin : g_pipe
      a_r7_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) |-> (valid_o == $past(valid_i)));
      a_r4_no_fixed_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) |-> (data_o != $past(data_i)));
      a_r2_zero_maps_to_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q != 2'd0) && $past(data_i) == 4'h0) |-> (data_o == 4'h7));
      a_r3_injective: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q == 2'd3) && $past(data_i) != $past(data_i, 2)) |-> (data_o != $past(data_o)));
      a_r8_reset_clears: assert property (@(posedge clk_i)
        !rst_ni |-> (!valid_o && data_o == 4'h7));
    end else begin : g_comb
      a_r9_valid_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == valid_i);
      a_r4_no_fixed_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_o != data_i);
      a_r2_zero_maps_to_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_i == 4'h0) |-> (data_o == 4'h7));
      a_r3_injective: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q != 2'd0) && $past(data_i) != data_i) |-> (data_o != $past(data_o)));
    end
  endgenerate
endmodule

bind sbox_tower sbox_tower_chk #(.PIPE(PIPE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .valid_o(valid_o), .data_o(data_o)
);

// File: tb/sim_sbox_tower.sv
module sim_sbox_tower;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [3:0] din = 4'h0;
  logic v0, v1;
  logic [3:0] d0, d1;
  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] obs [16];
  logic [3:0] tbl [16];

  always #4 clk = ~clk;

  sbox_tower #(.PIPE(1'b1)) u0 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din),
                                .valid_o(v0), .data_o(d0));
  sbox_tower #(.PIPE(1'b0)) u1 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din),
                                .valid_o(v1), .data_o(d1));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gmul(logic [3:0] a, logic [3:0] b);
    logic [4:0] acc;
    logic [4:0] aa;
    acc = '0;
    aa = {1'b0, a};
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa << 1;
      if (aa[4]) aa = aa ^ 5'h13;
    end
    return acc[3:0];
  endfunction

  function automatic logic [3:0] model(logic [3:0] x);
    logic [3:0] iv;
    iv = 4'h0;
    for (int y = 1; y < 16; y++) if (gmul(x, 4'(y)) == 4'h1) iv = 4'(y);
    return {iv[0], iv[1], iv[2], iv[3] ^ iv[0]} ^ 4'h7;
  endfunction

  initial begin : wd
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int dmax, lmax, cnt, b;
    logic seen [16];
    tbl = '{4'h7, 4'hE, 4'hF, 4'h0, 4'hD, 4'hB, 4'h8, 4'h1,
            4'h9, 4'h3, 4'h4, 4'hC, 4'h2, 4'h5, 4'hA, 4'h6};
    repeat (3) @(negedge clk);
    check("R8 valid_o in reset", {7'd0, v0}, 8'd0);
    check("R8 data_o in reset", {4'd0, d0}, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid_o after reset", {7'd0, v0}, 8'd0);

    // streaming sweep, one input per cycle
    for (int x = 0; x < 16; x++) begin
      vin = 1'b1;
      din = 4'(x);
      #1;
      check("R9 comb same-cycle data", {4'd0, d1}, {4'd0, tbl[x]});
      check("R9 comb valid passthrough", {7'd0, v1}, 8'd1);
      @(negedge clk);
      obs[x] = d0;
      check("R1 table", {4'd0, d0}, {4'd0, tbl[x]});
      check("R10 arithmetic model", {4'd0, d0}, {4'd0, model(4'(x))});
      check("R7 valid one cycle later", {7'd0, v0}, 8'd1);
    end
    check("R2 zero input", {4'd0, obs[0]}, 8'h07);

    for (int i = 0; i < 16; i++) seen[i] = 1'b0;
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      if (!seen[obs[i]]) cnt++;
      seen[obs[i]] = 1'b1;
    end
    check("R3 distinct outputs", 8'(cnt), 8'd16);
    cnt = 0;
    for (int i = 0; i < 16; i++) if (obs[i] == 4'(i)) cnt++;
    check("R4 fixed points", 8'(cnt), 8'd0);

    dmax = 0;
    for (int di = 1; di < 16; di++)
      for (int dd = 0; dd < 16; dd++) begin
        cnt = 0;
        for (int x = 0; x < 16; x++) if ((obs[x] ^ obs[x ^ di]) == 4'(dd)) cnt++;
        if (cnt > dmax) dmax = cnt;
      end
    check("R5 differential uniformity", 8'(dmax), 8'd4);

    lmax = 0;
    for (int ma = 1; ma < 16; ma++)
      for (int mb = 1; mb < 16; mb++) begin
        cnt = 0;
        for (int x = 0; x < 16; x++)
          if (^(4'(ma) & 4'(x)) == ^(4'(mb) & obs[x])) cnt++;
        b = (cnt > 8) ? cnt - 8 : 8 - cnt;
        if (b > lmax) lmax = b;
      end
    check("R6 linearity", 8'(lmax), 8'd4);

    // valid gap and data timing
    vin = 1'b0;
    din = 4'h3;
    #1;
    check("R9 comb valid low", {7'd0, v1}, 8'd0);
    check("R7 output still previous input", {4'd0, d0}, 8'h06);
    @(negedge clk);
    check("R7 valid low one cycle later", {7'd0, v0}, 8'd0);
    check("R7 data one cycle later", {4'd0, d0}, 8'h00);
    vin = 1'b1;
    din = 4'hA;
    @(negedge clk);
    check("R7 valid after gap", {7'd0, v0}, 8'd1);
    check("R1 input A", {4'd0, d0}, 8'h04);

    // mid-run reset
    vin = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 async clear valid", {7'd0, v0}, 8'd0);
    check("R8 async clear data", {4'd0, d0}, 8'h07);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule